// File: doc/BRIEF.md
# Serial receive character filter

This block sits between an asynchronous serial deserialiser and the receive store. Each received byte enters with its parity-error flag, framing-error flag and a line-break flag. The filter can clear the top data bit. It then compares the result with a set of programmable special characters and with an escape character. A received escape character makes the following character a plain literal. Once a line break has been reported, the filter can also watch for the break to end and raise a one-cycle exception pulse when it does.

Characters enter and leave through valid/ready handshakes, with one register stage between them. Configuration arrives on static input ports: strip enable, escape enable, match-on-error, end-of-break enable, the special characters and the escape character. The control path is a three-state machine. `ST_PLAIN` is normal matching. `ST_ESCAPED` means the next character is literal. `ST_BRK_HOLD` means a break was reported and its end is awaited. The transitions are:

- ESC_ARM: `ST_PLAIN` to `ST_ESCAPED` on an eligible escape character.
- ESC_DONE: `ST_ESCAPED` to `ST_PLAIN` on any accepted character.
- BRK_SEEN: any state to `ST_BRK_HOLD` on an accepted break character when end-of-break is enabled, otherwise to `ST_PLAIN`.
- BRK_END_CHR: `ST_BRK_HOLD` to `ST_PLAIN` or `ST_ESCAPED` on a non-break character.
- BRK_END_IDLE: `ST_BRK_HOLD` to `ST_PLAIN` on an idle line with no character accepted.

Top module: `rx_char_filter`

## Requirements
- R1: After reset, `out_valid` and `eob_pulse` are low and `in_ready` is high.
- R2: When `cfg_strip` is 1, bit 7 of every delivered character is 0. When `cfg_strip` is 0, the byte is delivered unchanged.
- R3: A character with `in_perr` or `in_ferr` set gets no match bits when `cfg_match_err` is 0. When `cfg_match_err` is 1, such a character is compared like a good one.
- R4: A character with `in_brk` set is delivered with `out_brk` set, its data after stripping, and no match bits.
- R5: Bit i of `out_match` is 1 exactly when an eligible character, after stripping, equals special character i. Special character i occupies `cfg_spec[8*i+7:8*i]`.
- R6: When `cfg_lnext_en` is 1, an eligible character equal to `cfg_lnext_chr` is delivered as data with no match bits. The character that follows it gets no match bits whatever its value, even if it is the escape character again.
- R7: The escape lasts exactly one character, so the character after the escaped one is matched normally. When `cfg_lnext_en` is 0, the escape character has no effect.
- R8: When `cfg_eob_en` is 1, the end of a break raises `eob_pulse` for exactly one cycle. The end of a break is the first accepted non-break character, or `line_idle` high while no character is accepted. The pulse appears the cycle after that event and occurs once per break.
- R9: When `cfg_eob_en` is 0, `eob_pulse` stays low.
- R10: A character accepted at one clock edge appears on the output after that edge. `in_ready` equals `!out_valid || out_ready`, and a stalled output holds its data and flags stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_strip | input | 1 | Clear the top data bit |
| cfg_lnext_en | input | 1 | Enable escape character handling |
| cfg_match_err | input | 1 | Also compare characters with errors |
| cfg_eob_en | input | 1 | Enable end-of-break reporting |
| cfg_spec | input | NUM_SPEC*DATA_W | Special characters, slot i at bits [8i+7:8i] |
| cfg_lnext_chr | input | DATA_W | Escape character |
| line_idle | input | 1 | Receive line is at idle mark |
| in_valid | input | 1 | Input character valid |
| in_ready | output | 1 | Input character accepted when valid |
| in_data | input | DATA_W | Received character |
| in_perr | input | 1 | Parity error |
| in_ferr | input | 1 | Framing error |
| in_brk | input | 1 | Line-break character |
| out_valid | output | 1 | Output character valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Filtered character |
| out_perr | output | 1 | Parity error, passed through |
| out_ferr | output | 1 | Framing error, passed through |
| out_brk | output | 1 | Break flag, passed through |
| out_match | output | NUM_SPEC | Per-slot special-character match |
| eob_pulse | output | 1 | End-of-break exception, one cycle |

## Verification
The properties compare the delivered character against the current configuration ports. They therefore assume that the configuration does not change while a character waits on the output or while a break is pending. The bench changes configuration only after it has drained the output with `out_ready` high. Before each change it also drives an idle-line cycle, so that any pending end of break completes while the old settings still apply. Input flags, data values, stalls and idle pulses are otherwise varied freely. The data values are biased towards the special characters and the escape character, with and without bit 7 set.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        ST_PLAIN    = 2'd0,
        ST_ESCAPED  = 2'd1,
        ST_BRK_HOLD = 2'd2
    } rxf_state_e;

    typedef struct packed {
        logic perr;
        logic ferr;
        logic brk;
    } rxf_flags_t;

endpackage

// File: rtl/rxf_classify.sv
module rxf_classify #(
    parameter int DATA_W   = 8,
    parameter int NUM_SPEC = 2
) (
    input  logic [DATA_W-1:0]          raw_data,
    input  rxf_pkg::rxf_flags_t        flags,
    input  logic                       escaped,
    input  logic                       cfg_strip,
    input  logic                       cfg_lnext_en,
    input  logic                       cfg_match_err,
    input  logic [NUM_SPEC*DATA_W-1:0] cfg_spec,
    input  logic [DATA_W-1:0]          cfg_lnext_chr,
    output logic [DATA_W-1:0]          clean_data,
    output logic [NUM_SPEC-1:0]        match_vec,
    output logic                       is_lnext
);
    localparam int TOP = DATA_W - 1;

    logic eligible;
    logic any_err;

    always_comb begin
        clean_data = raw_data;
        if (cfg_strip) begin
            clean_data[TOP] = 1'b0;
        end
    end

    assign any_err  = flags.perr | flags.ferr;
    assign eligible = !flags.brk && !escaped && (cfg_match_err || !any_err);
    assign is_lnext = eligible && cfg_lnext_en && (clean_data == cfg_lnext_chr);

    for (genvar i = 0; i < NUM_SPEC; i++) begin : g_cmp
        assign match_vec[i] = eligible && !is_lnext &&
                              (clean_data == cfg_spec[i*DATA_W +: DATA_W]);
    end

endmodule

// File: rtl/rxf_fsm.sv
module rxf_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic chr_brk,
    input  logic chr_lnext,
    input  logic line_idle,
    input  logic cfg_eob_en,
    output logic escaped,
    output logic eob_pulse
);
    import rxf_pkg::*;

    rxf_state_e state_q, state_d;
    logic       eob_d;
    logic       eob_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PLAIN;
            eob_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            eob_q   <= eob_d;
        end
    end

    always_comb begin
        state_d = state_q;
        eob_d   = 1'b0;
        unique case (state_q)
            ST_PLAIN: begin
                if (accept) begin
                    if (chr_brk) begin
                        state_d = cfg_eob_en ? ST_BRK_HOLD : ST_PLAIN;
                    end else if (chr_lnext) begin
                        state_d = ST_ESCAPED;
                    end
                end
            end
            ST_ESCAPED: begin
                if (accept) begin
                    if (chr_brk && cfg_eob_en) begin
                        state_d = ST_BRK_HOLD;
                    end else begin
                        state_d = ST_PLAIN;
                    end
                end
            end
            ST_BRK_HOLD: begin
                if (accept) begin
                    if (!chr_brk) begin
                        eob_d   = 1'b1;
                        state_d = chr_lnext ? ST_ESCAPED : ST_PLAIN;
                    end else if (!cfg_eob_en) begin
                        state_d = ST_PLAIN;
                    end
                end else if (line_idle) begin
                    eob_d   = 1'b1;
                    state_d = ST_PLAIN;
                end
            end
            default: state_d = ST_PLAIN;
        endcase
    end

    assign escaped   = (state_q == ST_ESCAPED);
    assign eob_pulse = eob_q;

endmodule

// File: rtl/rxf_out_stage.sv
module rxf_out_stage #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_payload,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_payload
);
    logic         vld_q;
    logic [W-1:0] pay_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            pay_q <= '0;
        end else if (in_valid && in_ready) begin
            vld_q <= 1'b1;
            pay_q <= in_payload;
        end else if (out_ready) begin
            vld_q <= 1'b0;
        end
    end

    assign out_valid   = vld_q;
    assign out_payload = pay_q;

endmodule

// File: rtl/rx_char_filter.sv
module rx_char_filter #(
    parameter int DATA_W   = 8,
    parameter int NUM_SPEC = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_strip,
    input  logic                       cfg_lnext_en,
    input  logic                       cfg_match_err,
    input  logic                       cfg_eob_en,
    input  logic [NUM_SPEC*DATA_W-1:0] cfg_spec,
    input  logic [DATA_W-1:0]          cfg_lnext_chr,
    input  logic                       line_idle,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [DATA_W-1:0]          in_data,
    input  logic                       in_perr,
    input  logic                       in_ferr,
    input  logic                       in_brk,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [DATA_W-1:0]          out_data,
    output logic                       out_perr,
    output logic                       out_ferr,
    output logic                       out_brk,
    output logic [NUM_SPEC-1:0]        out_match,
    output logic                       eob_pulse
);
    import rxf_pkg::*;

    localparam int FLAG_W = $bits(rxf_flags_t);
    localparam int PAY_W  = DATA_W + FLAG_W + NUM_SPEC;

    rxf_flags_t           in_flags;
    rxf_flags_t           q_flags;
    logic [DATA_W-1:0]    clean_data;
    logic [NUM_SPEC-1:0]  match_vec;
    logic                 is_lnext;
    logic                 escaped;
    logic                 accept;
    logic [PAY_W-1:0]     pay_in;
    logic [PAY_W-1:0]     pay_out;

    assign in_flags = '{perr: in_perr, ferr: in_ferr, brk: in_brk};
    assign accept   = in_valid && in_ready;

    rxf_classify #(
        .DATA_W   (DATA_W),
        .NUM_SPEC (NUM_SPEC)
    ) u_classify (
        .raw_data      (in_data),
        .flags         (in_flags),
        .escaped       (escaped),
        .cfg_strip     (cfg_strip),
        .cfg_lnext_en  (cfg_lnext_en),
        .cfg_match_err (cfg_match_err),
        .cfg_spec      (cfg_spec),
        .cfg_lnext_chr (cfg_lnext_chr),
        .clean_data    (clean_data),
        .match_vec     (match_vec),
        .is_lnext      (is_lnext)
    );

    rxf_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .chr_brk    (in_brk),
        .chr_lnext  (is_lnext),
        .line_idle  (line_idle),
        .cfg_eob_en (cfg_eob_en),
        .escaped    (escaped),
        .eob_pulse  (eob_pulse)
    );

    assign pay_in = {clean_data, in_flags, match_vec};

    rxf_out_stage #(
        .W (PAY_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_payload  (pay_in),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_payload (pay_out)
    );

    assign out_data  = pay_out[PAY_W-1 -: DATA_W];
    assign q_flags   = pay_out[NUM_SPEC +: FLAG_W];
    assign out_match = pay_out[NUM_SPEC-1:0];
    assign out_perr  = q_flags.perr;
    assign out_ferr  = q_flags.ferr;
    assign out_brk   = q_flags.brk;

endmodule

// File: rtl/rx_char_filter_chk.sv
module rx_char_filter_chk #(
    parameter int DATA_W   = 8,
    parameter int NUM_SPEC = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_strip,
    input logic                       cfg_match_err,
    input logic                       cfg_eob_en,
    input logic [NUM_SPEC*DATA_W-1:0] cfg_spec,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [DATA_W-1:0]          out_data,
    input logic                       out_perr,
    input logic                       out_ferr,
    input logic                       out_brk,
    input logic [NUM_SPEC-1:0]        out_match,
    input logic                       eob_pulse
);
    // R2
    strip_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_strip) |-> !out_data[DATA_W-1]);

    // R3
    err_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_perr || out_ferr) && !cfg_match_err) |-> (out_match == '0));

    // R4
    brk_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_brk) |-> (out_match == '0));

    for (genvar i = 0; i < NUM_SPEC; i++) begin : g_eq
        // R5
        match_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_match[i]) |-> (out_data == cfg_spec[i*DATA_W +: DATA_W]));
    end

    // R8
    eob_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eob_pulse |=> !eob_pulse);

    // R9
    eob_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eob_pulse |-> cfg_eob_en);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_match)
                                       && $stable(out_brk) && $stable(out_perr) && $stable(out_ferr)));

endmodule

bind rx_char_filter rx_char_filter_chk #(
    .DATA_W   (DATA_W),
    .NUM_SPEC (NUM_SPEC)
) u_chk (.*);

// File: tb/rx_char_filter_tb.sv
`timescale 1ns/1ps
module rx_char_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_strip = 0, cfg_lnext_en = 0, cfg_match_err = 0, cfg_eob_en = 0;
    logic [7:0]  spec0 = 8'h11, spec1 = 8'h13, lnext_chr = 8'h16;
    logic [15:0] cfg_spec;
    logic        line_idle = 0, in_valid = 0, in_perr = 0, in_ferr = 0, in_brk = 0;
    logic [7:0]  in_data = 0;
    logic        out_ready = 1;
    logic        in_ready, out_valid, out_perr, out_ferr, out_brk, eob_pulse;
    logic [7:0]  out_data;
    logic [1:0]  out_match;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    assign cfg_spec = {spec1, spec0};
    always #10 clk = ~clk;

    rx_char_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_strip(cfg_strip), .cfg_lnext_en(cfg_lnext_en),
        .cfg_match_err(cfg_match_err), .cfg_eob_en(cfg_eob_en), .cfg_spec(cfg_spec),
        .cfg_lnext_chr(lnext_chr), .line_idle(line_idle), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_perr(in_perr), .in_ferr(in_ferr),
        .in_brk(in_brk), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_perr(out_perr), .out_ferr(out_ferr), .out_brk(out_brk), .out_match(out_match),
        .eob_pulse(eob_pulse)
    );

    // behavioural reference model
    logic       m_valid = 0, m_pe = 0, m_fe = 0, m_brk = 0, m_eob = 0;
    logic [7:0] m_data = 0;
    logic [1:0] m_match = 0;
    int         m_st = 0;   // 0 plain, 1 escaped, 2 waiting for break end

    always @(posedge clk) begin
        logic [7:0] c;
        logic acc, elig, lnx;
        if (!rst_n) begin
            m_valid = 0; m_eob = 0; m_st = 0; m_match = 0;
        end else begin
            acc = in_valid && (!m_valid || out_ready);
            m_eob = 0;
            if (acc) begin
                c = in_data;
                if (cfg_strip) c[7] = 1'b0;
                elig = !in_brk && (m_st != 1) && (cfg_match_err || !(in_perr || in_ferr));
                lnx = elig && cfg_lnext_en && (c == lnext_chr);
                m_data = c; m_pe = in_perr; m_fe = in_ferr; m_brk = in_brk;
                m_match = 2'b00;
                if (elig && !lnx) begin
                    if (c == spec0) m_match[0] = 1'b1;
                    if (c == spec1) m_match[1] = 1'b1;
                end
                m_valid = 1;
                if (m_st == 2 && !in_brk) m_eob = 1;
                if (in_brk) m_st = cfg_eob_en ? 2 : 0;
                else m_st = lnx ? 1 : 0;
            end else begin
                if (out_ready) m_valid = 0;
                if (m_st == 2 && line_idle) begin m_eob = 1; m_st = 0; end
            end
        end
    end

    // per-cycle comparison with the model
    always begin
        @(negedge clk);
        #3;
        if (rst_n && !finished) begin
            bit err;
            err = 0;
            total++;
            if (out_valid !== m_valid || in_ready !== (!m_valid || out_ready)) begin
                err = 1;
                $display("FAIL R10 handshake: valid=%0b ready=%0b expected valid=%0b ready=%0b",
                         out_valid, in_ready, m_valid, (!m_valid || out_ready));
            end
            if (m_valid && out_data !== m_data) begin
                err = 1;
                $display("FAIL R2 data: got %h expected %h", out_data, m_data);
            end
            if (m_valid && {out_perr, out_ferr, out_brk} !== {m_pe, m_fe, m_brk}) begin
                err = 1;
                $display("FAIL R4 flags: got %b expected %b", {out_perr, out_ferr, out_brk}, {m_pe, m_fe, m_brk});
            end
            if (m_valid && out_match !== m_match) begin
                err = 1;
                $display("FAIL R5 match: got %b expected %b", out_match, m_match);
            end
            if (eob_pulse !== m_eob) begin
                err = 1;
                $display("FAIL R8 eob: got %b expected %b", eob_pulse, m_eob);
            end
            if (err) bad++;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic pe, input logic fe, input logic bk);
        @(negedge clk);
        in_valid = 1; in_data = d; in_perr = pe; in_ferr = fe; in_brk = bk;
        @(negedge clk);
        in_valid = 0; in_perr = 0; in_ferr = 0; in_brk = 0;
        #2;
    endtask

    task automatic idle_pulse();
        @(negedge clk);
        line_idle = 1;
        @(negedge clk);
        line_idle = 0;
        #2;
    endtask

    task automatic settle();
        @(negedge clk);
        in_valid = 0; out_ready = 1;
        idle_pulse();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state
        check("R1 out_valid", out_valid, 0);
        check("R1 in_ready", in_ready, 1);
        check("R1 eob_pulse", eob_pulse, 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2 strip off then on
        send(8'h93, 0, 0, 0);
        check("R2 strip off data", out_data, 8'h93);
        check("R5 no match 93", out_match, 2'b00);
        @(negedge clk); cfg_strip = 1;
        send(8'h93, 0, 0, 0);
        check("R2 strip on data", out_data, 8'h13);
        check("R5 slot1 match", out_match, 2'b10);
        send(8'h11, 0, 0, 0);
        check("R5 slot0 match", out_match, 2'b01);

        // R3 error rule
        send(8'h11, 1, 0, 0);
        check("R3 parity err no match", out_match, 2'b00);
        @(negedge clk); cfg_match_err = 1;
        send(8'h11, 0, 1, 0);
        check("R3 frame err matched", out_match, 2'b01);

        // R4 break char, R9 no eob when disabled
        send(8'h11, 0, 0, 1);
        check("R4 break flag", out_brk, 1);
        check("R4 break no match", out_match, 2'b00);
        send(8'h41, 0, 0, 0);
        check("R9 no eob", eob_pulse, 0);
        idle_pulse();
        check("R9 no eob idle", eob_pulse, 0);

        // R6 / R7 literal next
        @(negedge clk); cfg_lnext_en = 1;
        send(8'h16, 0, 0, 0);
        check("R6 escape delivered", out_data, 8'h16);
        check("R6 escape no match", out_match, 2'b00);
        send(8'h11, 0, 0, 0);
        check("R6 escaped char literal", out_match, 2'b00);
        send(8'h11, 0, 0, 0);
        check("R7 escape consumed", out_match, 2'b01);
        send(8'h16, 0, 0, 0);
        send(8'h16, 0, 0, 0);
        check("R6 escaped escape data", out_data, 8'h16);
        send(8'h13, 0, 0, 0);
        check("R6 double escape ends", out_match, 2'b10);
        @(negedge clk); cfg_lnext_en = 0;
        send(8'h16, 0, 0, 0);
        send(8'h11, 0, 0, 0);
        check("R7 escape disabled", out_match, 2'b01);

        // R8 end of break
        @(negedge clk); cfg_eob_en = 1;
        send(8'h00, 0, 1, 1);
        check("R8 no eob at break", eob_pulse, 0);
        send(8'h41, 0, 0, 0);
        check("R8 eob on char", eob_pulse, 1);
        @(negedge clk); #2;
        check("R8 eob one cycle", eob_pulse, 0);
        send(8'h00, 0, 0, 1);
        send(8'h00, 0, 0, 1);
        check("R8 no eob repeated break", eob_pulse, 0);
        idle_pulse();
        check("R8 eob on idle", eob_pulse, 1);
        idle_pulse();
        check("R8 eob once", eob_pulse, 0);

        // R10 stall
        @(negedge clk);
        @(negedge clk); out_ready = 0;
        send(8'h55, 0, 0, 0);
        check("R10 latency data", out_data, 8'h55);
        check("R10 ready low on stall", in_ready, 0);
        in_valid = 1; in_data = 8'h66;
        repeat (3) @(negedge clk);
        #2;
        check("R10 held data", out_data, 8'h55);
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        #2;
        check("R10 next data", out_data, 8'h66);

        // random traffic compared each cycle against the model
        for (int blk = 0; blk < 12; blk++) begin
            settle();
            cfg_strip = $urandom % 2; cfg_lnext_en = $urandom % 2;
            cfg_match_err = $urandom % 2; cfg_eob_en = $urandom % 2;
            for (int n = 0; n < 300; n++) begin
                int r;
                @(negedge clk);
                r = $urandom % 6;
                case (r)
                    0: in_data = spec0;
                    1: in_data = spec1;
                    2: in_data = lnext_chr;
                    3: in_data = lnext_chr | 8'h80;
                    4: in_data = spec0 | 8'h80;
                    default: in_data = 8'($urandom);
                endcase
                in_valid  = ($urandom % 4) != 0;
                in_perr   = ($urandom % 6) == 0;
                in_ferr   = ($urandom % 8) == 0;
                in_brk    = ($urandom % 9) == 0;
                out_ready = ($urandom % 4) != 0;
                line_idle = ($urandom % 10) == 0;
            end
            line_idle = 0;
        end
        settle();
        finish_run();
    end

endmodule